// File: doc/BRIEF.md
# Serial Word Framer and Decoder

This block receives 8-bit words over a three-wire serial link made of an active-low chip select, a serial clock and a data line. It runs entirely in a fast system-clock domain. The three serial pins and an active-low hardware reset pin pass through a two-stage synchroniser, and their edges are detected on the system clock. Data bits are shifted in most significant bit first on each rising serial clock while chip select is low.

Each chip-select burst is classified by its first complete word. A command word updates a 5-bit command register: a duty selector, a bias selector and a 3-bit port-select code, plus a decoded port mask. An address word loads a 4-bit start address and produces a one-cycle load pulse. Every later word in an address burst is passed downstream as display data with a one-cycle write strobe. Words that follow a command word, and every word of a burst whose first word is unrecognised, are dropped.

The controller is a four-state machine. `ST_IDLE` waits for chip select to fall. `ST_FIRST` waits for the first word. `ST_DATA` forwards words. `ST_SKIP` discards words. The transitions are:
- chip-select fall: `ST_IDLE` to `ST_FIRST`;
- address word: `ST_FIRST` to `ST_DATA`;
- command word or unknown word: `ST_FIRST` to `ST_SKIP`;
- chip-select rise: any state to `ST_IDLE`;
- reset: any state to `ST_IDLE`.

Top module: `serial_word_decoder`

## Requirements
- R1: Bits are taken on rising serial-clock edges only while chip select is low, and the first bit received becomes bit 7 of the word.
- R2: A word is confirmed on the falling serial-clock edge that follows its eighth bit. The resulting output pulse or register change appears on the fourth system-clock rising edge after the system-clock edge on which that pin edge was driven.
- R3: A word with fewer than eight bits when chip select rises is discarded. If chip select rises in the same cycle as the eighth falling clock edge, the word is confirmed exactly once.
- R4: A first word with bits 7:5 equal to 100 is a command. Bit 4 drives `duty_third` (1 means 1/3 duty, 0 means 1/4), bit 3 drives `bias_half` (1 means 1/2 bias, 0 means 1/3), and bits 2:0 drive `port_code`.
- R5: After a command word, no further word in the same burst changes any output.
- R6: A first word with bits 7:4 equal to 0111 raises `addr_load` for one cycle. `addr_val` takes bits 3:0 at that time and holds them until the next load or reset.
- R7: Every complete word after an address word in the same burst raises `data_wr` for one cycle with the word on `data_val`. `addr_load` and `data_wr` are never high together.
- R8: A burst whose first word matches neither the command pattern nor the address pattern produces no output activity.
- R9: The system reset, and the hardware reset pin (taking effect three system clocks after it is driven low), both set `duty_third`=0, `bias_half`=0, `port_code`=000, `port_mask`=0000 and `addr_val`=0000.
- R10: Releasing chip select ends the burst. The first word of the next burst is classified afresh.
- R11: `port_mask` bit i (bit 3 is the last output) is set when `port_code` is between 1 and 4 and i is at least 4 minus `port_code`. Codes 0, 5, 6 and 7 give an all-zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_rst_n | input | 1 | Asynchronous active-low hardware reset pin, synchronised |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data, MSB first |
| duty_third | output | 1 | 1 selects 1/3 duty, 0 selects 1/4 |
| bias_half | output | 1 | 1 selects 1/2 bias, 0 selects 1/3 |
| port_code | output | 3 | Raw port-select code |
| port_mask | output | 4 | Decoded mask of outputs used as plain ports |
| addr_load | output | 1 | One-cycle start-address load pulse |
| addr_val | output | 4 | Last loaded start address |
| data_wr | output | 1 | One-cycle display-data write strobe |
| data_val | output | 8 | Display data byte |

## Verification
The hardest case to reach from the pins is the coincidence of the chip-select release with the eighth falling serial-clock edge. At that point the confirm path and the end-of-burst path act in the same cycle and must produce exactly one word. The stimulus reaches it by driving both pins in the same cycle on the last bit of a data word. A second hard case is a partial word left in the shifter at release. The bench reaches it by abandoning a burst after three bits and then checking that the next burst is still classified from its own first word.

// File: rtl/swd_pkg.sv
package swd_pkg;

    localparam int WORD_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int CODE_W   = 3;
    localparam int CMD_W    = CODE_W + 2;
    localparam int DUTY_POS = 4;
    localparam int BIAS_POS = 3;

    localparam logic [2:0] CMD_TAG = 3'b100;
    localparam logic [3:0] ADR_TAG = 4'b0111;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_DATA,
        ST_SKIP
    } burst_st_t;

    typedef enum logic [1:0] {
        W_CMD,
        W_ADDR,
        W_OTHER
    } word_kind_t;

    function automatic word_kind_t classify(input logic [WORD_W-1:0] w);
        if (w[WORD_W-1 -: 3] == CMD_TAG)
            return W_CMD;
        else if (w[WORD_W-1 -: 4] == ADR_TAG)
            return W_ADDR;
        else
            return W_OTHER;
    endfunction

endpackage

// File: rtl/swd_sync.sv
module swd_sync #(
    parameter int         W       = 4,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stg[0] <= RST_VAL;
        else
            stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stg[s] <= RST_VAL;
            else
                stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/swd_shifter.sv
module swd_shifter
    import swd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              sdi_s,
    output logic              start_p,
    output logic              end_p,
    output logic              word_ok,
    output logic [WORD_W-1:0] word
);

    localparam int            CNT_W    = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    logic             cs_q, sck_q;
    logic [CNT_W-1:0] cnt;
    logic [WORD_W-1:0] shreg;
    logic             cs_fall, cs_rise, sck_rise, sck_fall, full;

    assign cs_fall  = cs_q & ~cs_n_s;
    assign cs_rise  = ~cs_q & cs_n_s;
    assign sck_rise = ~sck_q & sck_s;
    assign sck_fall = sck_q & ~sck_s;
    assign full     = (cnt == CNT_FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_n_s;
            sck_q <= sck_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            shreg   <= '0;
            start_p <= 1'b0;
            end_p   <= 1'b0;
            word_ok <= 1'b0;
            word    <= '0;
        end else if (srst) begin
            cnt     <= '0;
            start_p <= 1'b0;
            end_p   <= 1'b0;
            word_ok <= 1'b0;
        end else begin
            start_p <= cs_fall;
            end_p   <= cs_rise;
            word_ok <= 1'b0;
            if (cs_fall) begin
                cnt <= '0;
            end else if (full && (sck_fall || cs_rise)) begin
                word_ok <= 1'b1;
                word    <= shreg;
                cnt     <= '0;
            end else if (cs_rise) begin
                cnt <= '0;
            end else if (sck_rise && !cs_n_s && !full) begin
                shreg <= {shreg[WORD_W-2:0], sdi_s};
                cnt   <= cnt + 1'b1;
            end
        end
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_FULL);

    p_word_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_ok |=> !word_ok);

endmodule

// File: rtl/swd_port_map.sv
module swd_port_map
    import swd_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [NPORT-1:0]  mask
);

    logic in_range;
    assign in_range = (code != '0) && (int'(code) <= NPORT);

    for (genvar i = 0; i < NPORT; i++) begin : g_bit
        assign mask[i] = in_range && (i >= NPORT - int'(code));
    end

endmodule

// File: rtl/swd_ctrl.sv
module swd_ctrl
    import swd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              start_p,
    input  logic              end_p,
    input  logic              word_ok,
    input  logic [WORD_W-1:0] word,
    output logic              duty_third,
    output logic              bias_half,
    output logic [CODE_W-1:0] port_code,
    output logic              addr_load,
    output logic [ADDR_W-1:0] addr_val,
    output logic              data_wr,
    output logic [WORD_W-1:0] data_val
);

    burst_st_t  st, nxt;
    word_kind_t kind;

    assign kind = classify(word);

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (start_p) nxt = ST_FIRST;
            ST_FIRST: begin
                if (end_p)
                    nxt = ST_IDLE;
                else if (word_ok)
                    nxt = (kind == W_ADDR) ? ST_DATA : ST_SKIP;
            end
            ST_DATA:  if (end_p) nxt = ST_IDLE;
            ST_SKIP:  if (end_p) nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else if (srst)
            st <= ST_IDLE;
        else
            st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_third <= 1'b0;
            bias_half  <= 1'b0;
            port_code  <= '0;
            addr_load  <= 1'b0;
            addr_val   <= '0;
            data_wr    <= 1'b0;
            data_val   <= '0;
        end else if (srst) begin
            duty_third <= 1'b0;
            bias_half  <= 1'b0;
            port_code  <= '0;
            addr_load  <= 1'b0;
            addr_val   <= '0;
            data_wr    <= 1'b0;
        end else begin
            addr_load <= 1'b0;
            data_wr   <= 1'b0;
            if (word_ok && st == ST_FIRST && kind == W_CMD) begin
                duty_third <= word[DUTY_POS];
                bias_half  <= word[BIAS_POS];
                port_code  <= word[CODE_W-1:0];
            end
            if (word_ok && st == ST_FIRST && kind == W_ADDR) begin
                addr_load <= 1'b1;
                addr_val  <= word[ADDR_W-1:0];
            end
            if (word_ok && st == ST_DATA) begin
                data_wr  <= 1'b1;
                data_val <= word;
            end
        end
    end

    p_load_from_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |-> $past(st) == ST_FIRST);

    p_write_in_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |-> $past(st) == ST_DATA);

    p_cmd_only_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({duty_third, bias_half, port_code}) |-> ($past(st) == ST_FIRST || $past(srst)));

    p_idle_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        end_p |=> st == ST_IDLE);

endmodule

// File: rtl/serial_word_decoder.sv
module serial_word_decoder
    import swd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NPORT       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              duty_third,
    output logic              bias_half,
    output logic [CODE_W-1:0] port_code,
    output logic [NPORT-1:0]  port_mask,
    output logic              addr_load,
    output logic [ADDR_W-1:0] addr_val,
    output logic              data_wr,
    output logic [WORD_W-1:0] data_val
);

    localparam int PIN_N = 4;

    logic [PIN_N-1:0]  pins_s;
    logic              srst, start_p, end_p, word_ok;
    logic [WORD_W-1:0] word;

    swd_sync #(
        .W       (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hw_rst_n, cs_n, sck, sdi}),
        .q     (pins_s)
    );

    assign srst = ~pins_s[3];

    swd_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .srst    (srst),
        .cs_n_s  (pins_s[2]),
        .sck_s   (pins_s[1]),
        .sdi_s   (pins_s[0]),
        .start_p (start_p),
        .end_p   (end_p),
        .word_ok (word_ok),
        .word    (word)
    );

    swd_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst       (srst),
        .start_p    (start_p),
        .end_p      (end_p),
        .word_ok    (word_ok),
        .word       (word),
        .duty_third (duty_third),
        .bias_half  (bias_half),
        .port_code  (port_code),
        .addr_load  (addr_load),
        .addr_val   (addr_val),
        .data_wr    (data_wr),
        .data_val   (data_val)
    );

    swd_port_map #(.NPORT(NPORT)) u_pmap (
        .code (port_code),
        .mask (port_mask)
    );

    p_excl_pulses_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_load && data_wr));

    p_reset_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(srst) |-> (port_code == '0 && addr_val == '0 && !duty_third && !bias_half));

endmodule

// File: tb/tb_serial_word_decoder.sv
module tb_serial_word_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_rst_n = 1'b1;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       duty_third, bias_half, addr_load, data_wr;
    logic [2:0] port_code;
    logic [3:0] port_mask, addr_val;
    logic [7:0] data_val;

    serial_word_decoder dut (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .duty_third(duty_third), .bias_half(bias_half), .port_code(port_code),
        .port_mask(port_mask), .addr_load(addr_load), .addr_val(addr_val),
        .data_wr(data_wr), .data_val(data_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit fin = 0;
    int rst_at = -1;

    int cq_t[$]; int cq_v[$];
    int lq_t[$]; int lq_v[$];
    int wq_t[$]; int wq_v[$];

    int e_cmd = 0;
    int e_addr = 0;

    bit first_word = 0;
    bit data_mode = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic cmp(input string tag, input string nm, input int act, input int expv);
        compared++;
        if (act != expv) begin
            mismatched++;
            $display("FAIL %s %s act=%0d exp=%0d cyc=%0d", tag, nm, act, expv, cyc);
        end
    endtask

    function automatic int mask_of(input int code);
        int m = 0;
        if (code >= 1 && code <= 4)
            for (int k = 0; k < code; k++) m = m | (8 >> k);
        return m;
    endfunction

    // Reference model compared on every clock (R2 latency, R4, R6, R7, R11)
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            bit eld, ewr;
            int ewv;
            if (cyc == rst_at) begin
                e_cmd = 0;
                e_addr = 0;
            end
            while (cq_t.size() > 0 && cq_t[0] == cyc) begin
                e_cmd = cq_v[0];
                void'(cq_t.pop_front());
                void'(cq_v.pop_front());
            end
            eld = (lq_t.size() > 0 && lq_t[0] == cyc);
            if (eld) begin
                e_addr = lq_v[0];
                void'(lq_t.pop_front());
                void'(lq_v.pop_front());
            end
            ewr = (wq_t.size() > 0 && wq_t[0] == cyc);
            ewv = 0;
            if (ewr) begin
                ewv = wq_v[0];
                void'(wq_t.pop_front());
                void'(wq_v.pop_front());
            end
            cmp("R4", "duty_third", int'(duty_third), (e_cmd >> 4) & 1);
            cmp("R4", "bias_half", int'(bias_half), (e_cmd >> 3) & 1);
            cmp("R4", "port_code", int'(port_code), e_cmd & 7);
            cmp("R11", "port_mask", int'(port_mask), mask_of(e_cmd & 7));
            cmp("R6", "addr_load", int'(addr_load), int'(eld));
            cmp("R6", "addr_val", int'(addr_val), e_addr);
            cmp("R7", "data_wr", int'(data_wr), int'(ewr));
            if (ewr) cmp("R7", "data_val", int'(data_val), ewv);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Behavioural burst classification at the confirming pin edge
    task automatic model_word(input logic [7:0] w);
        if (first_word) begin
            first_word = 0;
            if (w[7:5] == 3'b100) begin
                cq_t.push_back(cyc + 4); cq_v.push_back(int'(w[4:0]));
                data_mode = 0;
            end else if (w[7:4] == 4'b0111) begin
                lq_t.push_back(cyc + 4); lq_v.push_back(int'(w[3:0]));
                data_mode = 1;
            end else begin
                data_mode = 0;
            end
        end else if (data_mode) begin
            wq_t.push_back(cyc + 4); wq_v.push_back(int'(w));
        end
    endtask

    task automatic begin_burst();
        cs_n = 1'b0;
        first_word = 1;
        data_mode = 0;
        tick(H);
    endtask

    task automatic end_burst();
        cs_n = 1'b1;
        first_word = 0;
        data_mode = 0;
        tick(2*H);
    endtask

    // MSB first on rising edges (R1); confirmed at eighth fall (R2)
    task automatic send_word(input logic [7:0] w, input bit joint_end);
        for (int i = 7; i >= 0; i--) begin
            sdi = w[i];
            tick(H);
            sck = 1'b1;
            tick(H);
            sck = 1'b0;
            if (i == 0) begin
                if (joint_end) cs_n = 1'b1;
                model_word(w);
                if (joint_end) begin
                    first_word = 0;
                    data_mode = 0;
                end
            end
            tick(H);
        end
    endtask

    task automatic send_bits(input logic [7:0] w, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            sdi = w[i];
            tick(H);
            sck = 1'b1;
            tick(H);
            sck = 1'b0;
            tick(H);
        end
    endtask

    task automatic pin_reset();
        hw_rst_n = 1'b0;
        rst_at = cyc + 3;
        tick(4);
        hw_rst_n = 1'b1;
        tick(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            fin = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R9: reset state
        cmp("R9", "reset duty", int'(duty_third), 0);
        cmp("R9", "reset bias", int'(bias_half), 0);
        cmp("R9", "reset code", int'(port_code), 0);
        cmp("R9", "reset addr", int'(addr_val), 0);
        cmp("R9", "reset mask", int'(port_mask), 0);

        // R4 command, then R5: trailing words in the same burst dropped
        begin_burst();
        send_word(8'h9B, 0);
        send_word(8'h7A, 0);
        send_word(8'h55, 0);
        end_burst();

        // R6 address, then R7 data words, R1 bit order
        begin_burst();
        send_word(8'h75, 0);
        send_word(8'hA5, 0);
        send_word(8'h3C, 0);
        send_word(8'h81, 0);
        end_burst();

        // R3: partial word at release is dropped
        begin_burst();
        send_word(8'h72, 0);
        send_word(8'h11, 0);
        send_bits(8'hF0, 3);
        end_burst();

        // R10: new burst classified afresh; first word 0x91 is a command
        begin_burst();
        send_word(8'h91, 0);
        end_burst();

        // R8: unknown first word ignores the burst
        begin_burst();
        send_word(8'h20, 0);
        send_word(8'h73, 0);
        send_word(8'hFF, 0);
        end_burst();

        // R3: release coincides with eighth falling edge
        begin_burst();
        send_word(8'h7C, 0);
        send_word(8'h66, 1);
        tick(2*H);

        // R3/R10: partial first word, then a fresh address burst
        begin_burst();
        send_bits(8'h7F, 5);
        end_burst();
        begin_burst();
        send_word(8'h7F, 0);
        send_word(8'hC3, 0);
        end_burst();

        // R11: every port code
        for (int c = 0; c < 8; c++) begin
            begin_burst();
            send_word(8'h80 | 8'(c), 0);
            end_burst();
        end

        // R9: hardware reset pin restores defaults
        begin_burst();
        send_word(8'h9C, 0);
        end_burst();
        begin_burst();
        send_word(8'h7E, 0);
        end_burst();
        pin_reset();
        cmp("R9", "pin reset duty", int'(duty_third), 0);
        cmp("R9", "pin reset addr", int'(addr_val), 0);
        cmp("R9", "pin reset mask", int'(port_mask), 0);

        // operation after pin reset
        begin_burst();
        send_word(8'h74, 0);
        send_word(8'h5A, 0);
        end_burst();
        tick(8);

        // R2: every scheduled event was consumed at its cycle
        cmp("R2", "pending events", cq_t.size() + lq_t.size() + wq_t.size(), 0);

        fin = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule